// File: doc/BRIEF.md
# End-of-Transfer Service Request Register

This block keeps, for sixteen transfer channels, two bit vectors: a select word that software writes to arm a channel, and a service word that hardware sets when a channel finishes its final transfer cycle. A completion pulse for a channel sets its service bit and disarms the channel by clearing its select bit. Both changes happen on the same clock edge. While any service bit is set, the block raises an interrupt request. It also presents the vector address of the pending channel with the highest number.

When the interrupt controller takes the interrupt, it returns an acknowledge with a channel index. That clears only the service bit of that channel. The select bit stays clear, so the end-of-transfer handler must write the select word again to re-arm the channel. A small state machine follows the service word. It is in `ST_IDLE` while no bit is set and in `ST_PENDING` while at least one bit is set. `ST_IDLE -> ST_PENDING` is taken when the next service word is non-zero. `ST_PENDING -> ST_IDLE` is taken when the next service word becomes zero. Both states hold otherwise.

Top module: `eot_svc_reg`

## Requirements
- R1: After reset the select word, the service word, `irq` and `vec_addr` are all zero.
- R2: A `done_pulse[n]` at a clock edge sets `svc_bits[n]` and clears `sel_bits[n]` at that same edge.
- R3: `irq` is 1 exactly when `svc_bits` is non-zero (state `ST_PENDING`), and 0 otherwise (state `ST_IDLE`).
- R4: An edge with `ack_valid`=1 and `ack_idx`=n clears `svc_bits[n]` and leaves every other service bit as it was.
- R5: `sel_wr_en`=1 loads the whole 16-bit `sel_bits` from `sel_wr_data`. A select bit cleared by completion stays 0 through the acknowledge until software writes 1 to it.
- R6: While `irq` is 1, `vec_addr` = `VEC_BASE` + 4*n for the selected channel n. Channel 0 maps to `VEC_BASE`+00H and channel 15 to `VEC_BASE`+3CH. While `irq` is 0, `vec_addr` is zero.
- R7: With several service bits set, the channel presented in `vec_addr` is the highest-numbered one.
- R8: When a write of 1 and a completion hit the same select bit at one edge, the select bit ends at 0.
- R9: An acknowledge for a channel whose service bit is clear changes neither word. `ack_valid`=0 also changes nothing.
- R10: When a completion and an acknowledge hit the same channel at one edge, the service bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| done_pulse | input | 16 | Per-channel final-cycle completion pulse from the transfer engine |
| ack_valid | input | 1 | Interrupt taken this cycle |
| ack_idx | input | 4 | Channel index of the taken interrupt |
| sel_wr_en | input | 1 | Software write strobe for the select word |
| sel_wr_data | input | 16 | Select word value to write |
| sel_bits | output | 16 | Current select (channel enable) word |
| svc_bits | output | 16 | Current pending service word |
| irq | output | 1 | End-of-transfer interrupt request |
| vec_addr | output | 24 | Vector address of the highest pending channel |

## Verification
The bench sweeps each of the sixteen channels through arm, complete, acknowledge and re-arm. A design that re-armed the select bit on acknowledge, or that mapped vector offsets wrongly, would fail on that channel. It also loads a mixed service pattern and acknowledges the presented channel one at a time. A design with an inverted priority would name the lowest channel first. Same-edge collisions are driven directly: a write of 1 together with a completion, which must leave the channel disarmed, and an acknowledge together with a completion, which must not lose the new request. Stray acknowledges are also driven, and a design that decoded the index carelessly would clear a neighbouring channel.

// File: rtl/eot_pkg.sv
package eot_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } eot_state_e;
endpackage

// File: rtl/eot_chan_cell.sv
module eot_chan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic ack_hit,
    input  logic wr_en,
    input  logic wr_bit,
    output logic sel_q,
    output logic svc_q,
    output logic svc_d
);
    logic sel_d;

    always_comb begin
        sel_d = sel_q;
        svc_d = svc_q;
        if (done) begin
            // completion overrides both software write and acknowledge
            sel_d = 1'b0;
            svc_d = 1'b1;
        end else begin
            if (ack_hit) svc_d = 1'b0;
            if (wr_en)   sel_d = wr_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            svc_q <= 1'b0;
        end else begin
            sel_q <= sel_d;
            svc_q <= svc_d;
        end
    end

    a_r2_done_sets_and_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (svc_q && !sel_q));
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !done) |=> !svc_q);
    a_r5_sel_rises_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_q) |-> $past(wr_en));
    a_r8_hw_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_en && wr_bit) |=> !sel_q);
    a_r9_idle_ack_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !svc_q && !done && !wr_en) |=> (!svc_q && $stable(sel_q)));
    a_r10_done_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ack_hit) |=> svc_q);
endmodule

// File: rtl/eot_prio_enc.sv
module eot_prio_enc #(
    parameter int NCH   = 16,
    localparam int IDXW = $clog2(NCH)
) (
    input  logic [NCH-1:0]  req,
    output logic            any,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        // ascending scan: the last hit (highest number) wins
        for (int i = 0; i < NCH; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDXW'(i);
            end
        end
    end
endmodule

// File: rtl/eot_svc_reg.sv
module eot_svc_reg #(
    parameter int NCH                = 16,
    parameter int ADDR_W             = 24,
    parameter logic [ADDR_W-1:0] VEC_BASE = 24'hFF2100,
    parameter int VEC_STRIDE         = 4,
    localparam int IDXW              = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    done_pulse,
    input  logic              ack_valid,
    input  logic [IDXW-1:0]   ack_idx,
    input  logic              sel_wr_en,
    input  logic [NCH-1:0]    sel_wr_data,
    output logic [NCH-1:0]    sel_bits,
    output logic [NCH-1:0]    svc_bits,
    output logic              irq,
    output logic [ADDR_W-1:0] vec_addr
);
    import eot_pkg::*;

    logic [NCH-1:0]  svc_next;
    logic [NCH-1:0]  ack_hit;
    logic            top_any;
    logic [IDXW-1:0] top_idx;
    eot_state_e      state_q, state_d;

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        assign ack_hit[n] = ack_valid && (ack_idx == IDXW'(n));
        eot_chan_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .done    (done_pulse[n]),
            .ack_hit (ack_hit[n]),
            .wr_en   (sel_wr_en),
            .wr_bit  (sel_wr_data[n]),
            .sel_q   (sel_bits[n]),
            .svc_q   (svc_bits[n]),
            .svc_d   (svc_next[n])
        );
    end

    eot_prio_enc #(.NCH(NCH)) u_prio (
        .req (svc_bits),
        .any (top_any),
        .idx (top_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (|svc_next)  state_d = ST_PENDING;
            ST_PENDING: if (~|svc_next) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq      = 1'b0;
        vec_addr = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PENDING: begin
                irq      = 1'b1;
                vec_addr = VEC_BASE + ADDR_W'(top_idx) * ADDR_W'(VEC_STRIDE);
            end
            default: ;
        endcase
    end

    a_r3_irq_tracks_service: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|svc_bits));
    a_r7_highest_presented: assert property (@(posedge clk) disable iff (!rst_n)
        top_any |-> (svc_bits[top_idx] && ((svc_bits >> top_idx) >> 1) == '0));
    a_r6_vec_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec_addr >= VEC_BASE &&
                 vec_addr <= VEC_BASE + ADDR_W'((NCH-1) * VEC_STRIDE)));
    a_r6_vec_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec_addr == '0));
endmodule

// File: tb/eot_svc_reg_tb_top.sv
module eot_svc_reg_tb_top;
    localparam int CLK_P = 10;
    localparam logic [23:0] BASE = 24'hFF2100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] done_pulse = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_idx = '0;
    logic        sel_wr_en = 1'b0;
    logic [15:0] sel_wr_data = '0;
    logic [15:0] sel_bits, svc_bits;
    logic        irq;
    logic [23:0] vec_addr;

    int tests = 0;
    int fails = 0;
    logic [15:0] m_sel = '0;
    logic [15:0] m_svc = '0;

    always #(CLK_P/2) clk = ~clk;

    eot_svc_reg dut_i (
        .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .ack_valid(ack_valid),
        .ack_idx(ack_idx), .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
        .sel_bits(sel_bits), .svc_bits(svc_bits), .irq(irq), .vec_addr(vec_addr)
    );

    function automatic logic [23:0] exp_vec(input logic [15:0] s);
        logic [23:0] v = '0;
        for (int i = 0; i < 16; i++) if (s[i]) v = BASE + 24'(4 * i);
        return v;
    endfunction

    function automatic int top_chan(input logic [15:0] s);
        int t = -1;
        for (int i = 0; i < 16; i++) if (s[i]) t = i;
        return t;
    endfunction

    task automatic chk(input string tag, input string what, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "sel_bits", 24'(sel_bits), 24'(m_sel));
        chk(tag, "svc_bits", 24'(svc_bits), 24'(m_svc));
        chk(tag, "irq", 24'(irq), 24'(|m_svc));
        chk(tag, "vec_addr", vec_addr, exp_vec(m_svc));
    endtask

    // called at a negedge; returns at the following negedge after checking
    task automatic step(input logic [15:0] d, input logic av, input logic [3:0] ai,
                        input logic we, input logic [15:0] wd, input string tag);
        done_pulse = d; ack_valid = av; ack_idx = ai; sel_wr_en = we; sel_wr_data = wd;
        @(posedge clk);
        if (we) m_sel = wd;
        m_sel = m_sel & ~d;
        if (av) m_svc = m_svc & ~(16'h1 << ai);
        m_svc = m_svc | d;
        @(negedge clk);
        done_pulse = '0; ack_valid = 1'b0; ack_idx = '0; sel_wr_en = 1'b0; sel_wr_data = '0;
        check_all(tag);
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2 R4 R5 R6: every channel through arm, complete, ack, re-arm
        for (int n = 0; n < 16; n++) begin
            step(16'h0, 1'b0, 4'd0, 1'b1, 16'hFFFF, "R5");
            step(16'h1 << n, 1'b0, 4'd0, 1'b0, 16'h0, "R2");
            chk("R6", "channel vector", vec_addr, BASE + 24'(4 * n));
            chk("R3", "irq while pending", 24'(irq), 24'd1);
            step(16'h0, 1'b1, 4'(n), 1'b0, 16'h0, "R4");
            chk("R5", "select stays clear after ack", 24'(sel_bits[n]), 24'd0);
            chk("R3", "irq after ack", 24'(irq), 24'd0);
            step(16'h0, 1'b0, 4'd0, 1'b0, 16'h0, "R5");
            step(16'h0, 1'b0, 4'd0, 1'b1, 16'hFFFF, "R5");
        end

        // R7: several pending, acknowledge the presented channel each time
        step(16'hA5C3, 1'b0, 4'd0, 1'b0, 16'h0, "R7");
        chk("R7", "first vector is channel 15", vec_addr, BASE + 24'h3C);
        while (m_svc != 0) begin
            int t;
            t = top_chan(m_svc);
            chk("R7", "highest presented", vec_addr, BASE + 24'(4 * t));
            step(16'h0, 1'b1, 4'(t), 1'b0, 16'h0, "R7");
        end

        // R9: ack of a clear channel and ack_valid low change nothing
        step(16'h0010, 1'b0, 4'd0, 1'b1, 16'h0F0F, "R9");
        step(16'h0, 1'b1, 4'd5, 1'b0, 16'h0, "R9");
        step(16'h0, 1'b0, 4'd4, 1'b0, 16'h0, "R9");
        chk("R9", "service kept", 24'(svc_bits), 24'h0010);

        // R8: write of one and completion on same select bit
        step(16'h0008, 1'b0, 4'd0, 1'b1, 16'hFFFF, "R8");
        chk("R8", "select bit 3 clear", 24'(sel_bits[3]), 24'd0);

        // R10: completion and ack on the same channel
        step(16'h0080, 1'b1, 4'd7, 1'b0, 16'h0, "R10");
        chk("R10", "service bit 7 kept", 24'(svc_bits[7]), 24'd1);

        // R1: reset again with state present
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_sel = '0; m_svc = '0;
        check_all("R1");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule